// File: doc/BRIEF.md
# Power management event router

This block holds the status, enable and control state for a set of power-management events and turns pending events into interrupt requests. Five event sources (timer, global, power button, sleep button, real-time-clock alarm) each latch a status bit from a one-cycle pulse. Software clears a status bit by writing a 1 to it. Each enabled, pending source is steered to a system control interrupt (SCI) or a system management interrupt (SMI). Timer and global events always go to SCI. The other three follow a select bit in the control register.

Beside the routing, two small state machines run in the control path. The release machine has the states `REL_IDLE` and `REL_HELD`. Its transitions are: `REL_IDLE -> REL_HELD` on a control write with the release bit set, `REL_HELD -> REL_IDLE` on a write-one to the firmware flag, and a hold in every other case. While it is in `REL_HELD`, both the release bit and the firmware flag read as 1.

The sleep machine has the states `SLP_IDLE` and `SLP_FIRE`. Its transitions are: `SLP_IDLE -> SLP_FIRE` on a control write that sets the sleep-enable bit with a valid type, `SLP_FIRE -> SLP_FIRE` when another such write arrives in that cycle, and `SLP_FIRE -> SLP_IDLE` otherwise. In `SLP_FIRE` it drives the sleep request for one cycle. A sleep write with a reserved type leaves the machine in `SLP_IDLE` and sets a sticky error flag instead.

The register port has a write strobe, a 2-bit address and 16-bit data. Read data is a combinational function of the address. Register addresses:

- 0: status
- 1: enable
- 2: control
- 3: firmware

Top module: `pm_event_router`

## Requirements
- R1: After reset, all four registers read 0000h, and `sci`, `smi`, `bm_reload`, `fw_flag`, `rsvd_err` and `sleep_req` are low, with `sleep_type` at 0.
- R2: The enable register (address 1) stores the following bits, and all other bits read 0. Bit 0 is timer, bit 5 is global, bit 8 is power button, bit 9 is sleep button and bit 10 is RTC alarm.
- R3: A pulse on an event input sets the status bit (address 0) with the same position as in R2 at the next edge. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When a pulse and a clearing write land in the same cycle, the bit stays set.
- R4: While timer status and timer enable are both 1, or global status and global enable are both 1, `sci` is high, whatever the value of the select bit.
- R5: An enabled, pending power-button, sleep-button or RTC event drives `sci` when control bit 0 (select) is 1 and drives `smi` when it is 0. A disabled source drives neither output.
- R6: `sci` and `smi` are levels that change in the cycle after the register change that causes them. Each drops once every contributing source is cleared or disabled.
- R7: Control register (address 2) fields:
  - bit 0: select.
  - bit 1: bus-master reload, driven on `bm_reload`.
  - bits 12:10: sleep type.
  - bit 13: sleep enable, which always reads 0.
  - bits 15:14 and 9:3: read 0.
- R8: Writing control with bit 2 set makes control bit 2 and firmware bit 0 (`fw_flag`) read 1 from the next cycle. Writing control with bit 2 at 0 leaves both unchanged.
- R9: Writing 1 to firmware register bit 0 clears the firmware flag and control bit 2 together at the next edge.
- R10: A control write with bit 13 set and a type of 0, 1, 5, 6 or 7 (S0, S1, S3, S4, S5) raises `sleep_req` for exactly the next cycle, with `sleep_type` equal to the written type. `sleep_type` holds that value afterwards.
- R11: A control write with bit 13 set and a type of 2, 3 or 4 issues no request, and `sleep_type` keeps its value. It sets `rsvd_err`, which reads as firmware bit 1. Writing 1 to firmware bit 1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Register write strobe |
| io_addr | input | 2 | Register address |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data for `io_addr` |
| ev_tmr | input | 1 | Timer event pulse |
| ev_gbl | input | 1 | Global event pulse |
| ev_pwrbtn | input | 1 | Power-button event pulse |
| ev_slpbtn | input | 1 | Sleep-button event pulse |
| ev_rtc | input | 1 | RTC alarm event pulse |
| sci | output | 1 | System control interrupt level |
| smi | output | 1 | System management interrupt level |
| bm_reload | output | 1 | Bus-master reload enable level |
| fw_flag | output | 1 | Firmware status flag |
| rsvd_err | output | 1 | Reserved sleep type error flag |
| sleep_req | output | 1 | One-cycle sleep request |
| sleep_type | output | 3 | Sleep type carried with the request |

## Verification
A status or enable bit held in the wrong value shows up on `sci` or `smi` in the cycle after the event or write that exposed it. It also shows on the matching read-back bit in that same cycle. A release machine stuck in either state is visible on `fw_flag` and control bit 2 one cycle after the set write or the clearing write. A sleep machine that sticks in `SLP_FIRE`, or that fires on a reserved type, produces a wrong `sleep_req` in the cycle after the write. The bench compares every output and the read data of the addressed register against a behavioural model on every clock, so any of these faults is reported within one cycle.

// File: rtl/pm_router_pkg.sv
package pm_router_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 2;
    localparam int NSRC   = 5;
    localparam int TYPE_W = 3;

    // source order: timer, global, power button, sleep button, rtc
    localparam int SRC_POS [NSRC] = '{0, 5, 8, 9, 10};
    localparam logic [NSRC-1:0] SCI_ONLY = 5'b00011;

    localparam logic [ADDR_W-1:0] ADR_STAT = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_EN   = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_FW   = 2'd3;

    localparam int CT_SEL   = 0;
    localparam int CT_BMR   = 1;
    localparam int CT_RLS   = 2;
    localparam int CT_TYP   = 10;
    localparam int CT_SLPEN = 13;

    localparam int FW_FLAG = 0;
    localparam int FW_ERR  = 1;

    typedef enum logic {REL_IDLE, REL_HELD} rel_state_t;
    typedef enum logic {SLP_IDLE, SLP_FIRE} slp_state_t;

    function automatic logic type_reserved(input logic [TYPE_W-1:0] t);
        return (t == 3'd2) || (t == 3'd3) || (t == 3'd4);
    endfunction
endpackage

// File: rtl/pm_status_regs.sv
module pm_status_regs
    import pm_router_pkg::*;
#(
    parameter int N = NSRC,
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         wr_stat,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [N-1:0] st_bits,
    output logic [N-1:0] en_bits,
    output logic [W-1:0] stat_word,
    output logic [W-1:0] en_word
);
    for (genvar g = 0; g < N; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_bits[g] <= 1'b0;
                en_bits[g] <= 1'b0;
            end else begin
                if (ev[g]) begin
                    st_bits[g] <= 1'b1;
                end else if (wr_stat && wdata[SRC_POS[g]]) begin
                    st_bits[g] <= 1'b0;
                end
                if (wr_en) begin
                    en_bits[g] <= wdata[SRC_POS[g]];
                end
            end
        end
    end

    always_comb begin
        stat_word = '0;
        en_word   = '0;
        for (int i = 0; i < N; i++) begin
            stat_word[SRC_POS[i]] = st_bits[i];
            en_word[SRC_POS[i]]   = en_bits[i];
        end
    end
endmodule

// File: rtl/pm_int_route.sv
module pm_int_route
    import pm_router_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] st_bits,
    input  logic [N-1:0] en_bits,
    input  logic         sel_sci,
    output logic         sci,
    output logic         smi
);
    logic [N-1:0] pend;
    logic         fixed_hit;
    logic         steer_hit;

    always_comb begin
        pend      = st_bits & en_bits;
        fixed_hit = |(pend & SCI_ONLY);
        steer_hit = |(pend & ~SCI_ONLY);
        sci       = fixed_hit | (sel_sci & steer_hit);
        smi       = ~sel_sci & steer_hit;
    end
endmodule

// File: rtl/pm_ctrl_fsm.sv
module pm_ctrl_fsm
    import pm_router_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int TW = TYPE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          wr_fw,
    input  logic [W-1:0]  wdata,
    output logic          sel_sci,
    output logic          bm_reload,
    output logic [TW-1:0] typ,
    output logic          rls,
    output logic          rsvd_err,
    output logic          sleep_req,
    output logic [TW-1:0] sleep_type
);
    rel_state_t    rel_q, rel_d;
    slp_state_t    slp_q, slp_d;
    logic [TW-1:0] wr_typ;
    logic          wr_sleep;
    logic          typ_bad;
    logic          fire_ok;

    assign wr_typ   = wdata[CT_TYP +: TW];
    assign wr_sleep = wr_ctrl && wdata[CT_SLPEN];
    assign typ_bad  = type_reserved(wr_typ);
    assign fire_ok  = wr_sleep && !typ_bad;

    // next-state logic
    always_comb begin
        rel_d = rel_q;
        unique case (rel_q)
            REL_IDLE: if (wr_ctrl && wdata[CT_RLS]) rel_d = REL_HELD;
            REL_HELD: if (wr_fw && wdata[FW_FLAG])  rel_d = REL_IDLE;
        endcase
        slp_d = slp_q;
        unique case (slp_q)
            SLP_IDLE: if (fire_ok) slp_d = SLP_FIRE;
            SLP_FIRE: slp_d = fire_ok ? SLP_FIRE : SLP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_q <= REL_IDLE;
            slp_q <= SLP_IDLE;
        end else begin
            rel_q <= rel_d;
            slp_q <= slp_d;
        end
    end

    // state outputs
    always_comb begin
        rls       = (rel_q == REL_HELD);
        sleep_req = (slp_q == SLP_FIRE);
    end

    // plain control fields and latched request payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_sci    <= 1'b0;
            bm_reload  <= 1'b0;
            typ        <= '0;
            sleep_type <= '0;
            rsvd_err   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                sel_sci   <= wdata[CT_SEL];
                bm_reload <= wdata[CT_BMR];
                typ       <= wr_typ;
            end
            if (fire_ok) begin
                sleep_type <= wr_typ;
            end
            if (wr_sleep && typ_bad) begin
                rsvd_err <= 1'b1;
            end else if (wr_fw && wdata[FW_ERR]) begin
                rsvd_err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pm_event_router.sv
module pm_event_router
    import pm_router_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int AW = ADDR_W,
    parameter int TW = TYPE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_wr,
    input  logic [AW-1:0] io_addr,
    input  logic [W-1:0]  io_wdata,
    output logic [W-1:0]  io_rdata,
    input  logic          ev_tmr,
    input  logic          ev_gbl,
    input  logic          ev_pwrbtn,
    input  logic          ev_slpbtn,
    input  logic          ev_rtc,
    output logic          sci,
    output logic          smi,
    output logic          bm_reload,
    output logic          fw_flag,
    output logic          rsvd_err,
    output logic          sleep_req,
    output logic [TW-1:0] sleep_type
);
    localparam int N = NSRC;

    logic [N-1:0]  ev_vec;
    logic [N-1:0]  st_bits, en_bits;
    logic [W-1:0]  stat_q, en_q;
    logic          sel_q, rls_q;
    logic [TW-1:0] typ_q;
    logic          wr_stat, wr_en, wr_ctrl, wr_fw;

    assign ev_vec  = {ev_rtc, ev_slpbtn, ev_pwrbtn, ev_gbl, ev_tmr};
    assign wr_stat = io_wr && (io_addr == ADR_STAT);
    assign wr_en   = io_wr && (io_addr == ADR_EN);
    assign wr_ctrl = io_wr && (io_addr == ADR_CTRL);
    assign wr_fw   = io_wr && (io_addr == ADR_FW);

    pm_status_regs #(.N(N), .W(W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev_vec),
        .wr_stat   (wr_stat),
        .wr_en     (wr_en),
        .wdata     (io_wdata),
        .st_bits   (st_bits),
        .en_bits   (en_bits),
        .stat_word (stat_q),
        .en_word   (en_q)
    );

    pm_int_route #(.N(N)) u_route (
        .st_bits (st_bits),
        .en_bits (en_bits),
        .sel_sci (sel_q),
        .sci     (sci),
        .smi     (smi)
    );

    pm_ctrl_fsm #(.W(W), .TW(TW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wr_fw      (wr_fw),
        .wdata      (io_wdata),
        .sel_sci    (sel_q),
        .bm_reload  (bm_reload),
        .typ        (typ_q),
        .rls        (rls_q),
        .rsvd_err   (rsvd_err),
        .sleep_req  (sleep_req),
        .sleep_type (sleep_type)
    );

    assign fw_flag = rls_q;

    always_comb begin
        io_rdata = '0;
        unique case (io_addr)
            ADR_STAT: io_rdata = stat_q;
            ADR_EN:   io_rdata = en_q;
            ADR_CTRL: begin
                io_rdata[CT_SEL]       = sel_q;
                io_rdata[CT_BMR]       = bm_reload;
                io_rdata[CT_RLS]       = rls_q;
                io_rdata[CT_TYP +: TW] = typ_q;
            end
            ADR_FW: begin
                io_rdata[FW_FLAG] = rls_q;
                io_rdata[FW_ERR]  = rsvd_err;
            end
        endcase
    end
endmodule

// File: rtl/pm_event_router_chk.sv
module pm_event_router_chk
    import pm_router_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        io_wr,
    input logic [1:0]  io_addr,
    input logic [15:0] io_wdata,
    input logic        ev_tmr,
    input logic        sci,
    input logic        smi,
    input logic        fw_flag,
    input logic        rsvd_err,
    input logic        sleep_req,
    input logic [2:0]  sleep_type,
    input logic [15:0] stat_q,
    input logic [15:0] en_q,
    input logic        sel_q
);
    logic ctrl_sleep_wr;
    assign ctrl_sleep_wr = io_wr && (io_addr == ADR_CTRL) && io_wdata[CT_SLPEN];

    p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tmr |=> stat_q[0]);

    p_tmr_forces_sci_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[0] && en_q[0]) |-> sci);

    p_smi_needs_sel0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        smi |-> !sel_q);

    p_flag_from_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fw_flag) |-> $past(io_wr && io_addr == ADR_CTRL && io_wdata[CT_RLS]));

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !ctrl_sleep_wr) |=> !sleep_req);

    p_valid_type_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> !type_reserved(sleep_type));

    p_reserved_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_sleep_wr && type_reserved(io_wdata[CT_TYP +: 3])) |=> (!sleep_req && rsvd_err));
endmodule

bind pm_event_router pm_event_router_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_wr      (io_wr),
    .io_addr    (io_addr),
    .io_wdata   (io_wdata),
    .ev_tmr     (ev_tmr),
    .sci        (sci),
    .smi        (smi),
    .fw_flag    (fw_flag),
    .rsvd_err   (rsvd_err),
    .sleep_req  (sleep_req),
    .sleep_type (sleep_type),
    .stat_q     (stat_q),
    .en_q       (en_q),
    .sel_q      (sel_q)
);

// File: tb/sim_pm_event_router.sv
module sim_pm_event_router;
    localparam int CLK_P = 10;
    localparam int QTR   = CLK_P / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [1:0]  io_addr = 2'd0;
    logic [15:0] io_wdata = 16'h0;
    logic [15:0] io_rdata;
    logic        ev_tmr = 1'b0, ev_gbl = 1'b0, ev_pwrbtn = 1'b0, ev_slpbtn = 1'b0, ev_rtc = 1'b0;
    logic        sci, smi, bm_reload, fw_flag, rsvd_err, sleep_req;
    logic [2:0]  sleep_type;

    int    vectors = 0;
    int    fails = 0;
    bit    done = 0;
    string phase = "R1 reset";

    pm_event_router u0 (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .ev_tmr(ev_tmr), .ev_gbl(ev_gbl), .ev_pwrbtn(ev_pwrbtn),
        .ev_slpbtn(ev_slpbtn), .ev_rtc(ev_rtc),
        .sci(sci), .smi(smi), .bm_reload(bm_reload), .fw_flag(fw_flag),
        .rsvd_err(rsvd_err), .sleep_req(sleep_req), .sleep_type(sleep_type)
    );

    always #(CLK_P/2) clk = ~clk;

    // behavioural reference model
    logic [15:0] m_st = 0, m_en = 0;
    bit          m_sel = 0, m_bm = 0, m_rls = 0, m_err = 0, m_req = 0;
    int          m_typ = 0, m_styp = 0;

    function automatic bit reserved(int t);
        return t >= 2 && t <= 4;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_en = 0; m_sel = 0; m_bm = 0; m_rls = 0;
            m_err = 0; m_req = 0; m_typ = 0; m_styp = 0;
        end else begin
            logic [15:0] evm;
            int t;
            evm = 0;
            evm[0] = ev_tmr; evm[5] = ev_gbl; evm[8] = ev_pwrbtn;
            evm[9] = ev_slpbtn; evm[10] = ev_rtc;
            m_req = 0;
            if (io_wr && io_addr == 0) m_st = m_st & ~io_wdata;
            m_st = (m_st | evm) & 16'h0721;
            if (io_wr && io_addr == 1) m_en = io_wdata & 16'h0721;
            if (io_wr && io_addr == 2) begin
                t = int'(io_wdata[12:10]);
                m_sel = io_wdata[0];
                m_bm  = io_wdata[1];
                m_typ = t;
                if (io_wdata[2]) m_rls = 1;
                if (io_wdata[13]) begin
                    if (reserved(t)) m_err = 1;
                    else begin m_req = 1; m_styp = t; end
                end
            end
            if (io_wr && io_addr == 3) begin
                if (io_wdata[0]) m_rls = 0;
                if (io_wdata[1]) m_err = 0;
            end
        end
    end

    task automatic cmp(string what, string req, int got, int exp);
        if (got != exp) begin
            fails++;
            $display("FAIL %s [%s] %s: got %0h expected %0h", req, phase, what, got, exp);
        end
    endtask

    task automatic check_all();
        logic [15:0] pend, rd;
        bit e_sci, e_smi, steer;
        pend  = m_st & m_en;
        steer = (pend & 16'h0700) != 0;
        e_sci = ((pend & 16'h0021) != 0) || (m_sel && steer);
        e_smi = !m_sel && steer;
        case (io_addr)
            2'd0: rd = m_st;
            2'd1: rd = m_en;
            2'd2: rd = 16'(m_typ << 10) | 16'(m_rls << 2) | 16'(m_bm << 1) | 16'(m_sel);
            default: rd = 16'(m_err << 1) | 16'(m_rls);
        endcase
        vectors++;
        cmp("sci", "R4", sci, e_sci);
        cmp("smi", "R5", smi, e_smi);
        cmp("bm_reload", "R7", bm_reload, m_bm);
        cmp("fw_flag", "R9", fw_flag, m_rls);
        cmp("rsvd_err", "R11", rsvd_err, m_err);
        cmp("sleep_req", "R10", sleep_req, m_req);
        cmp("sleep_type", "R10", sleep_type, m_styp);
        cmp("io_rdata", "R2", io_rdata, rd);
    endtask

    task automatic tick();
        @(posedge clk);
        #(QTR);
        check_all();
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        io_wr = 1; io_addr = a; io_wdata = d;
        tick();
        io_wr = 0; io_wdata = 0;
    endtask

    task automatic rd(logic [1:0] a);
        io_addr = a;
        tick();
    endtask

    task automatic ev(logic [4:0] m);
        {ev_rtc, ev_slpbtn, ev_pwrbtn, ev_gbl, ev_tmr} = m;
        tick();
        {ev_rtc, ev_slpbtn, ev_pwrbtn, ev_gbl, ev_tmr} = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #(QTR);
        rst_n = 1;
        // R1: reset values on every register and output
        phase = "R1 reset";
        cmp("sci", "R1", sci, 0);
        cmp("sleep_req", "R1", sleep_req, 0);
        for (int a = 0; a < 4; a++) rd(2'(a));

        // R2: enable storage and reserved bits
        phase = "R2 enable";
        wr(1, 16'hFFFF); rd(1);
        wr(1, 16'h0000); rd(1);
        wr(1, 16'h0500); rd(1);
        wr(1, 16'h0000);

        // R3: status set, write-one-to-clear, set wins
        phase = "R3 status";
        io_addr = 0;
        ev(5'b00001); rd(0);
        wr(0, 16'hFFFE); rd(0);
        wr(0, 16'h0001); rd(0);
        ev(5'b11110); rd(0);
        io_wr = 1; io_addr = 0; io_wdata = 16'h0100; ev_pwrbtn = 1;
        tick();
        io_wr = 0; ev_pwrbtn = 0; io_wdata = 0;
        rd(0);
        wr(0, 16'hFFFF); rd(0);

        // R4: timer and global go to SCI regardless of select
        phase = "R4 fixed sci";
        wr(1, 16'h0021); wr(2, 16'h0000);
        ev(5'b00001); rd(0);
        // R6: level drops once cleared
        phase = "R6 drop";
        wr(0, 16'h0001); rd(0);
        phase = "R4 fixed sci";
        ev(5'b00010); rd(0);
        wr(2, 16'h0001); rd(2);
        phase = "R6 drop";
        wr(0, 16'h0020); rd(0);

        // R5: steered sources follow select
        phase = "R5 steer";
        wr(1, 16'h0700); wr(2, 16'h0000);
        ev(5'b00100); rd(0);
        wr(2, 16'h0001); rd(0);
        wr(2, 16'h0000); rd(0);
        ev(5'b11000); wr(0, 16'h0100); rd(0);
        phase = "R6 drop";
        wr(0, 16'h0200); rd(0);
        wr(1, 16'h0000); rd(0);
        wr(0, 16'h0400); rd(0);
        phase = "R5 disabled";
        ev(5'b11111); rd(0);
        wr(0, 16'hFFFF);

        // R7: control fields and zero bits
        phase = "R7 control";
        wr(2, 16'hC3FA); rd(2);
        wr(2, 16'h1402); rd(2);
        wr(2, 16'h0000); rd(2);

        // R8 / R9: release handshake
        phase = "R8 release";
        wr(2, 16'h0004); rd(2); rd(3);
        wr(2, 16'h0000); rd(2); rd(3);
        phase = "R9 fw clear";
        wr(3, 16'h0002); rd(3);
        wr(3, 16'h0001); rd(3); rd(2);

        // R10 / R11: sleep request for every type
        for (int t = 0; t < 8; t++) begin
            phase = reserved(t) ? "R11 reserved type" : "R10 sleep";
            wr(2, 16'h2000 | 16'(t << 10));
            rd(2); rd(3);
        end
        phase = "R10 back to back";
        wr(2, 16'h2400); wr(2, 16'h3C00); rd(2);
        phase = "R11 err clear";
        wr(2, 16'h2C00); rd(3);
        wr(3, 16'h0001); rd(3);
        wr(3, 16'h0002); rd(3);
        repeat (3) rd(0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule